// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. A start request begins a conversion. The block first holds the external integrator discharged for a programmable number of clocks. It then connects the unknown input to the integrator for a fixed number of clocks, N1. Last, it switches the integrator to the negative reference and counts clocks until the zero-crossing comparator reports that the integrator output is no longer above zero.

That second count, N2, is the conversion result. Because the input is ratioed against the reference over the same fixed interval, the input equals the reference times N2 / N1. If the comparator never trips within a bounded number of run-down clocks, the count saturates and an overrange flag is raised. A one-cycle done pulse marks each finished conversion. The result and flag hold their values until the next conversion completes.

Top module: `dslope_seq`

## Requirements
- R1: While reset is high, and after reset until a start is accepted, the block is idle: `int_reset`, `sel_input`, `sel_ref` and `done` are 0, and `result` and `overrange` are 0.
- R2: A start accepted in idle is followed, from the next cycle, by exactly `az_len`+1 cycles with `int_reset` high and both selects low.
- R3: Directly after auto-zero, `sel_input` is high for exactly N1 consecutive cycles, whatever the comparator does.
- R4: Directly after run-up, `sel_ref` stays high until the run-down ends. At no time is more than one of `int_reset`, `sel_input`, `sel_ref` high.
- R5: `cmp_pos` = 1 means the integrator output is above zero. The result equals the number of run-down cycles in which `cmp_pos` was sampled 1 before the first cycle in which it was sampled 0.
- R6: `done` is high for exactly one cycle, the cycle after the last run-down cycle. `result` and `overrange` change only in a cycle where `done` is high.
- R7: If `cmp_pos` is still 1 in the run-down cycle whose count equals NMAX, the run-down ends with `result` = NMAX and `overrange` = 1. A comparator drop in that same cycle gives `result` = NMAX with `overrange` = 0.
- R8: A start request during a conversion is ignored: it neither restarts nor extends any phase, and no new conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled in idle only |
| az_len | input | AZ_W | Auto-zero length minus one, in clocks |
| cmp_pos | input | 1 | Comparator: 1 while integrator output is above zero |
| int_reset | output | 1 | Holds the integrator discharged |
| sel_input | output | 1 | Connects the unknown input to the integrator |
| sel_ref | output | 1 | Connects the negative reference to the integrator |
| result | output | RES_W | Run-down count N2 of the last conversion |
| overrange | output | 1 | Last conversion saturated at NMAX |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench couples the sequencer to a behavioural integrator. It drives inputs that make the run-down stop at once (zero input), stop mid-range, stop exactly on the NMAX cycle, or run past it.

An off-by-one in the run-down counter shows up as a result one too high or too low. A wrong saturation compare flags overrange on the exact-NMAX case, or misses it on the case just beyond. Auto-zero with `az_len` of 0 and of a larger value, and a start pulsed in mid run-up, expose a phase that is one clock too long or a sequencer that restarts when busy.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_AZERO = 2'd1,
        PH_RUNUP = 2'd2,
        PH_RUNDN = 2'd3
    } phase_e;

    typedef struct packed {
        logic int_reset;
        logic sel_input;
        logic sel_ref;
    } sw_t;

    typedef enum logic [1:0] {
        TM_HOLD = 2'd0,
        TM_LOAD = 2'd1,
        TM_INC  = 2'd2,
        TM_DEC  = 2'd3
    } tmop_e;

    function automatic sw_t phase_switches(phase_e ph);
        sw_t s;
        s = '0;
        case (ph)
            PH_AZERO: s.int_reset = 1'b1;
            PH_RUNUP: s.sel_input = 1'b1;
            PH_RUNDN: s.sel_ref   = 1'b1;
            default:  s = '0;
        endcase
        return s;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dslope_timer.sv
module dslope_timer #(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  dslope_pkg::tmop_e   op,
    input  logic [CNT_W-1:0]    load_val,
    output logic [CNT_W-1:0]    cnt
);
    import dslope_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                TM_LOAD: cnt <= load_val;
                TM_INC:  cnt <= cnt + 1'b1;
                TM_DEC:  cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl #(
    parameter int N1    = 1000,
    parameter int NMAX  = 2047,
    parameter int AZ_W  = 8,
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmp_pos,
    input  logic [AZ_W-1:0]     az_len,
    input  logic [CNT_W-1:0]    cnt,
    output dslope_pkg::phase_e  phase,
    output dslope_pkg::tmop_e   tm_op,
    output logic [CNT_W-1:0]    tm_load,
    output logic                finish,
    output logic                sat
);
    import dslope_pkg::*;

    localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(N1 - 1);
    localparam logic [CNT_W-1:0] RUNDN_LAST = CNT_W'(NMAX);

    phase_e ph_q, ph_d;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    always_comb begin
        ph_d    = ph_q;
        tm_op   = TM_HOLD;
        tm_load = '0;
        finish  = 1'b0;
        sat     = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d    = PH_AZERO;
                    tm_op   = TM_LOAD;
                    tm_load = CNT_W'(az_len);
                end
            end
            PH_AZERO: begin
                if (cnt == '0) begin
                    ph_d  = PH_RUNUP;
                    tm_op = TM_LOAD;
                end else begin
                    tm_op = TM_DEC;
                end
            end
            PH_RUNUP: begin
                if (cnt == RUNUP_LAST) begin
                    ph_d  = PH_RUNDN;
                    tm_op = TM_LOAD;
                end else begin
                    tm_op = TM_INC;
                end
            end
            PH_RUNDN: begin
                if (!cmp_pos) begin
                    ph_d   = PH_IDLE;
                    finish = 1'b1;
                end else if (cnt == RUNDN_LAST) begin
                    ph_d   = PH_IDLE;
                    finish = 1'b1;
                    sat    = 1'b1;
                end else begin
                    tm_op = TM_INC;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    assign phase = ph_q;

endmodule

// File: rtl/dslope_capture.sv
module dslope_capture #(
    parameter int NMAX  = 2047,
    parameter int RES_W = 11,
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                finish,
    input  logic                sat,
    input  logic [CNT_W-1:0]    cnt,
    output logic [RES_W-1:0]    result,
    output logic                overrange,
    output logic                done
);
    localparam logic [RES_W-1:0] RES_SAT = RES_W'(NMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            overrange <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result    <= sat ? RES_SAT : cnt[RES_W-1:0];
                overrange <= sat;
            end
        end
    end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int N1   = 1000,
    parameter int NMAX = 2047,
    parameter int AZ_W = 8,
    localparam int RES_W = $clog2(NMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AZ_W-1:0]  az_len,
    input  logic             cmp_pos,
    output logic             int_reset,
    output logic             sel_input,
    output logic             sel_ref,
    output logic [RES_W-1:0] result,
    output logic             overrange,
    output logic             done
);
    import dslope_pkg::*;

    localparam int CNT_W = max3(AZ_W, $clog2(N1), RES_W);

    phase_e           phase;
    tmop_e            tm_op;
    logic [CNT_W-1:0] tm_load;
    logic [CNT_W-1:0] cnt;
    logic             finish;
    logic             sat;
    sw_t              sw;

    dslope_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .op       (tm_op),
        .load_val (tm_load),
        .cnt      (cnt)
    );

    dslope_ctrl #(.N1(N1), .NMAX(NMAX), .AZ_W(AZ_W), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmp_pos (cmp_pos),
        .az_len  (az_len),
        .cnt     (cnt),
        .phase   (phase),
        .tm_op   (tm_op),
        .tm_load (tm_load),
        .finish  (finish),
        .sat     (sat)
    );

    dslope_capture #(.NMAX(NMAX), .RES_W(RES_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .sat       (sat),
        .cnt       (cnt),
        .result    (result),
        .overrange (overrange),
        .done      (done)
    );

    assign sw        = phase_switches(phase);
    assign int_reset = sw.int_reset;
    assign sel_input = sw.sel_input;
    assign sel_ref   = sw.sel_ref;

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int N1    = 1000,
    parameter int NMAX  = 2047,
    parameter int RES_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             int_reset,
    input logic             sel_input,
    input logic             sel_ref,
    input logic [RES_W-1:0] result,
    input logic             overrange,
    input logic             done
);
    int up_run;

    always_ff @(posedge clk) begin
        if (rst)            up_run <= 0;
        else if (sel_input) up_run <= up_run + 1;
        else                up_run <= 0;
    end

    assert_switch_excl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({int_reset, sel_input, sel_ref}));

    assert_runup_bound_R3: assert property (@(posedge clk) disable iff (rst)
        sel_input |-> (up_run < N1));

    assert_runup_exact_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_input) |-> (up_run == N1));

    assert_runup_to_ref_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_input) |-> sel_ref);

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !int_reset && !sel_input && !sel_ref && !done) |=> int_reset);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ref_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(sel_ref));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(overrange)));

    assert_ovr_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        overrange |-> (result == RES_W'(NMAX)));

endmodule

bind dslope_seq dslope_seq_chk #(.N1(N1), .NMAX(NMAX), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .int_reset (int_reset),
    .sel_input (sel_input),
    .sel_ref   (sel_ref),
    .result    (result),
    .overrange (overrange),
    .done      (done)
);

// File: tb/dslope_seq_test.sv
module dslope_seq_test;
    localparam int N1    = 16;
    localparam int NMAX  = 40;
    localparam int AZ_W  = 4;
    localparam int RES_W = $clog2(NMAX + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [AZ_W-1:0]  az_len = '0;
    logic             cmp_pos = 1'b0;
    logic             int_reset, sel_input, sel_ref, overrange, done;
    logic [RES_W-1:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int vin = 0;
    int vref = 4;
    int integ = 0;

    // reference model state (behavioural)
    int m_ph = 0;
    int m_cnt = 0;
    int m_res = 0;
    int m_ovr = 0;
    int m_done = 0;

    always #2.5 clk = ~clk;

    dslope_seq #(.N1(N1), .NMAX(NMAX), .AZ_W(AZ_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .az_len    (az_len),
        .cmp_pos   (cmp_pos),
        .int_reset (int_reset),
        .sel_input (sel_input),
        .sel_ref   (sel_ref),
        .result    (result),
        .overrange (overrange),
        .done      (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model steps at the active edge using values that settled at the previous negedge
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_res = 0; m_ovr = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin m_ph = 1; m_cnt = int'(az_len); end
            end else if (m_ph == 1) begin
                if (m_cnt == 0) begin m_ph = 2; m_cnt = 0; end
                else m_cnt = m_cnt - 1;
            end else if (m_ph == 2) begin
                if (m_cnt == N1 - 1) begin m_ph = 3; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (!cmp_pos) begin
                    m_res = m_cnt; m_ovr = 0; m_done = 1; m_ph = 0;
                end else if (m_cnt == NMAX) begin
                    m_res = NMAX; m_ovr = 1; m_done = 1; m_ph = 0;
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    // per-clock comparison, then behavioural integrator and comparator
    always @(negedge clk) begin
        if (!finished) begin
            check(int_reset == (m_ph == 1), "R2 int_reset", int'(int_reset), int'(m_ph == 1));
            check(sel_input == (m_ph == 2), "R3 sel_input", int'(sel_input), int'(m_ph == 2));
            check(sel_ref   == (m_ph == 3), "R4 sel_ref",   int'(sel_ref),   int'(m_ph == 3));
            check(done == m_done[0],        "R6 done",      int'(done),      m_done);
            check(int'(result) == m_res,    "R5 result",    int'(result),    m_res);
            check(overrange == m_ovr[0],    "R7 overrange", int'(overrange), m_ovr);
        end
        if (int_reset)      integ = 0;
        else if (sel_input) integ = integ + vin;
        else if (sel_ref)   integ = integ - vref;
        cmp_pos = (integ > 0);
    end

    function automatic int exp_count(int vi, int vr);
        int k;
        k = (N1 * vi + vr - 1) / vr - 1;
        if (k < 0) k = 0;
        return k;
    endfunction

    task automatic run_conv(input int vi, input int vr, input int az, input string tag);
        int n_az, n_up, n_dn, k, e_res, e_ovr;
        bit got;
        n_az = 0; n_up = 0; n_dn = 0; got = 0;
        vin = vi; vref = vr; az_len = AZ_W'(az);
        k = exp_count(vi, vr);
        e_ovr = (k > NMAX) ? 1 : 0;
        e_res = e_ovr ? NMAX : k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (int_reset) n_az++;
            if (sel_input) n_up++;
            if (sel_ref)   n_dn++;
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check(got, {tag, " R6 done seen"}, int'(got), 1);
        check(n_az == az + 1, {tag, " R2 auto-zero length"}, n_az, az + 1);
        check(n_up == N1, {tag, " R3 run-up length"}, n_up, N1);
        check(n_dn == e_res + 1, {tag, " R4 run-down length"}, n_dn, e_res + 1);
        check(int'(result) == e_res, {tag, " R5 result"}, int'(result), e_res);
        check(int'(overrange) == e_ovr, {tag, " R7 overrange"}, int'(overrange), e_ovr);
        @(negedge clk);
        check(!done, {tag, " R6 done one cycle"}, int'(done), 0);
        check(int'(result) == e_res, {tag, " R6 result held"}, int'(result), e_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!int_reset && !sel_input && !sel_ref && !done, "R1 outputs in reset",
              int'({int_reset, sel_input, sel_ref, done}), 0);
        check(result == '0 && !overrange, "R1 result in reset", int'(result), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!int_reset && !sel_input && !sel_ref, "R1 idle after reset",
              int'({int_reset, sel_input, sel_ref}), 0);

        run_conv(3, 4, 2, "mid");
        run_conv(1, 4, 0, "small");
        run_conv(0, 4, 5, "zero");
        run_conv(41, 16, 1, "atmax");
        run_conv(42, 16, 1, "beyond");
        run_conv(20, 4, 3, "far");
        run_conv(5, 8, 15, "longaz");

        // R8: start pulsed mid run-up is ignored
        begin
            int n_up, n_az_after;
            bit got;
            n_up = 0; got = 0;
            vin = 3; vref = 4; az_len = AZ_W'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 500; i++) begin
                if (sel_input) n_up++;
                if (n_up == 5) start = 1'b1;
                else start = 1'b0;
                if (done) begin got = 1; break; end
                @(negedge clk);
            end
            start = 1'b0;
            check(got, "R8 conversion completes", int'(got), 1);
            check(n_up == N1, "R8 run-up not extended", n_up, N1);
            check(int'(result) == exp_count(3, 4), "R8 result", int'(result), exp_count(3, 4));
            n_az_after = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (int_reset || sel_input || sel_ref) n_az_after++;
            end
            check(n_az_after == 0, "R8 no new conversion", n_az_after, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule